// File: doc/BRIEF.md
# Multi-port buffered handshake stage

This block is one stage of a valid/ready pipeline. An item accepted on the input side passes through a fixed combinational transform. The result is held in an output register and offered downstream. An item travels on a port when that port's valid and ready are both high at a rising clock edge. The transform works on two operand fields of the item: the upper half is operand A and the lower half is operand B. By default it adds them and keeps the carry.

The stage can face several upstream ports or several downstream ports, but not both at once:

- **Several upstream ports:** an externally driven index picks which upstream port is served.
- **Several downstream ports:** a second index picks which downstream port is offered the result.
- **A single port on a side:** the index on that side is ignored and the port is used directly.

A second register, the skid register, absorbs one extra item. It catches an item that is accepted in a cycle when the held result is not taken downstream. While that register is occupied, the stage refuses new input. On the next free cycle it forwards the buffered item ahead of anything newer.

Top module: `hsk_mport_stage`

## Requirements
- R1: An item accepted while the output register is empty, or while its current result is taken in the same cycle, appears with valid high on the selected downstream port in the cycle right after the accepting edge.
- R2: The result is RES_W = OP_W+1 bits wide and is computed from A = item[2*OP_W-1:OP_W] and B = item[OP_W-1:0], both zero-extended to RES_W. The mode parameter selects the operation:
  - mode 0: A+B
  - mode 1: A-B modulo 2^RES_W
  - mode 2: A XOR B
- R3: With more than one upstream port, ready can be high only on the port whose index equals in_sel. Every other port sees ready low, and its valid is ignored. An in_sel value of NUM_IN or above serves no port.
- R4: With more than one downstream port, valid can be high only on the port whose index equals out_sel. An out_sel value of NUM_OUT or above offers the result on no port, and the held item is kept. Every downstream data lane carries the same result.
- R5: An item accepted while the held result is not taken is captured in the skid register, and no item is lost. From the next cycle until the skid register drains, ready is low on every upstream port.
- R6: Items leave in the order they were accepted. A buffered item moves to the output register before any newer item.
- R7: While a result is offered on a port that is not ready, and out_sel does not change, valid stays high and the data stays unchanged.
- R8: Synchronous active-high reset empties both the output register and the skid register. In the first cycle after reset, every downstream valid is low and the selected upstream port sees ready high.
- R9: With a single upstream port, in_sel is ignored. With a single downstream port, out_sel is ignored.
- R10: A configuration with more than one upstream port and more than one downstream port, or with zero ports on either side, is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | NUM_IN | Valid from each upstream port |
| up_data | input | NUM_IN*2*OP_W | Items from each upstream port; port p occupies bits [p*2*OP_W +: 2*OP_W] |
| up_ready | output | NUM_IN | Ready to each upstream port |
| in_sel | input | max(1,clog2(NUM_IN)) | Index of the upstream port to serve |
| dn_valid | output | NUM_OUT | Valid to each downstream port |
| dn_data | output | NUM_OUT*(OP_W+1) | Result lanes, one per downstream port, all carrying the same value |
| dn_ready | input | NUM_OUT | Ready from each downstream port |
| out_sel | input | max(1,clog2(NUM_OUT)) | Index of the downstream port to offer the result to |

## Verification
A skid flag that fails to clear leaves every upstream ready low indefinitely. This shows at the ports one cycle after the buffered item should have moved. A flag that fails to set, or a buffered item that is dropped, leaves the downstream stream one item short or out of order. The scoreboard sees this at the next downstream transfer. A selection or routing fault raises ready or valid on the wrong port in the same cycle. A held result that changes while stalled shows on the data lane on the very next edge.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  // Transform selection codes for the processing function.
  localparam int XF_ADD = 0;
  localparam int XF_SUB = 1;
  localparam int XF_XOR = 2;

  // Width of a port-select index for n ports (at least one bit).
  function automatic int sel_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hsk_in_select.sv
module hsk_in_select #(
  parameter int NUM_IN = 1,
  parameter int IN_W   = 16,
  parameter int ISW    = 1
) (
  input  logic [NUM_IN-1:0]      up_valid,
  input  logic [NUM_IN*IN_W-1:0] up_data,
  input  logic [ISW-1:0]         in_sel,
  input  logic                   can_accept,
  output logic [NUM_IN-1:0]      up_ready,
  output logic                   sel_valid,
  output logic [IN_W-1:0]        sel_data
);

  generate
    if (NUM_IN == 1) begin : g_direct
      // Single upstream port: used directly, selector ignored.
      logic unused_sel;
      assign unused_sel = ^in_sel;
      assign up_ready   = can_accept;
      assign sel_valid  = up_valid[0];
      assign sel_data   = up_data;
    end else begin : g_mux
      logic [NUM_IN-1:0] hit;
      for (genvar p = 0; p < NUM_IN; p++) begin : g_port
        assign hit[p] = (in_sel == ISW'(p));
      end
      assign up_ready  = hit & {NUM_IN{can_accept}};
      assign sel_valid = |(hit & up_valid);
      always_comb begin
        sel_data = '0;
        for (int p = 0; p < NUM_IN; p++) begin
          if (hit[p]) sel_data = up_data[p*IN_W +: IN_W];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/hsk_xform.sv
module hsk_xform
  import hsk_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int OP_MODE = XF_ADD,
  localparam int IN_W   = 2 * OP_W,
  localparam int RES_W  = OP_W + 1
) (
  input  logic [IN_W-1:0]  item,
  output logic [RES_W-1:0] res
);

  logic [RES_W-1:0] a_x;
  logic [RES_W-1:0] b_x;

  assign a_x = {1'b0, item[IN_W-1:OP_W]};
  assign b_x = {1'b0, item[OP_W-1:0]};

  generate
    if (OP_MODE == XF_ADD) begin : g_add
      assign res = a_x + b_x;
    end else if (OP_MODE == XF_SUB) begin : g_sub
      assign res = a_x - b_x;
    end else if (OP_MODE == XF_XOR) begin : g_xor
      assign res = a_x ^ b_x;
    end else begin : g_bad_mode
      $error("hsk_xform: unknown OP_MODE");
      assign res = '0;
    end
  endgenerate

endmodule

// File: rtl/hsk_skid_core.sv
module hsk_skid_core #(
  parameter int RES_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [RES_W-1:0] in_res,
  input  logic             dn_ready_sel,
  output logic             can_accept,
  output logic             accept,
  output logic             take,
  output logic             out_valid,
  output logic [RES_W-1:0] out_data,
  output logic             skid_full
);

  logic             ov_q;
  logic             sk_q;
  logic [RES_W-1:0] od_q;
  logic [RES_W-1:0] sd_q;
  logic             out_free;

  // Ready depends only on a flop, so no combinational path from downstream ready.
  assign can_accept = ~sk_q;
  assign accept     = in_valid & can_accept;
  assign take       = ov_q & dn_ready_sel;
  assign out_free   = ~ov_q | take;

  // Control flags: the only reset state.
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      sk_q <= 1'b0;
    end else if (out_free) begin
      ov_q <= sk_q | accept;
      sk_q <= 1'b0;
    end else if (accept) begin
      sk_q <= 1'b1;
    end
  end

  // Data registers: no reset, the buffered item always has priority.
  always_ff @(posedge clk) begin
    if (out_free) begin
      if (sk_q) begin
        od_q <= sd_q;
      end else if (accept) begin
        od_q <= in_res;
      end
    end
    if (!out_free && accept) begin
      sd_q <= in_res;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign skid_full = sk_q;

endmodule

// File: rtl/hsk_out_route.sv
module hsk_out_route #(
  parameter int NUM_OUT = 1,
  parameter int RES_W   = 9,
  parameter int OSW     = 1
) (
  input  logic                     out_valid,
  input  logic [RES_W-1:0]         out_data,
  input  logic [OSW-1:0]           out_sel,
  input  logic [NUM_OUT-1:0]       dn_ready,
  output logic [NUM_OUT-1:0]       dn_valid,
  output logic [NUM_OUT*RES_W-1:0] dn_data,
  output logic                     dn_ready_sel
);

  assign dn_data = {NUM_OUT{out_data}};

  generate
    if (NUM_OUT == 1) begin : g_direct
      // Single downstream port: used directly, selector ignored.
      logic unused_sel;
      assign unused_sel   = ^out_sel;
      assign dn_valid     = out_valid;
      assign dn_ready_sel = dn_ready[0];
    end else begin : g_route
      logic [NUM_OUT-1:0] hit;
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_port
        assign hit[k] = (out_sel == OSW'(k));
      end
      assign dn_valid     = hit & {NUM_OUT{out_valid}};
      assign dn_ready_sel = |(hit & dn_ready);
    end
  endgenerate

endmodule

// File: rtl/hsk_mport_stage.sv
module hsk_mport_stage
  import hsk_pkg::*;
#(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 1,
  parameter int OP_W    = 8,
  parameter int OP_MODE = XF_ADD,
  localparam int IN_W   = 2 * OP_W,
  localparam int RES_W  = OP_W + 1,
  localparam int ISW    = sel_w(NUM_IN),
  localparam int OSW    = sel_w(NUM_OUT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        up_valid,
  input  logic [NUM_IN*IN_W-1:0]   up_data,
  output logic [NUM_IN-1:0]        up_ready,
  input  logic [ISW-1:0]           in_sel,
  output logic [NUM_OUT-1:0]       dn_valid,
  output logic [NUM_OUT*RES_W-1:0] dn_data,
  input  logic [NUM_OUT-1:0]       dn_ready,
  input  logic [OSW-1:0]           out_sel
);

  // R10: only one side may be multi-port.
  generate
    if (NUM_IN < 1 || NUM_OUT < 1) begin : g_bad_count
      $error("hsk_mport_stage: port counts must be at least one");
    end
    if (NUM_IN > 1 && NUM_OUT > 1) begin : g_bad_combo
      $error("hsk_mport_stage: multiple inputs with multiple outputs is not supported");
    end
  endgenerate

  logic             sel_valid;
  logic [IN_W-1:0]  sel_data;
  logic [RES_W-1:0] xf_res;
  logic             can_accept;
  logic             core_accept;
  logic             core_take;
  logic             core_valid;
  logic [RES_W-1:0] core_data;
  logic             core_skid_full;
  logic             dn_ready_sel;

  hsk_in_select #(
    .NUM_IN (NUM_IN),
    .IN_W   (IN_W),
    .ISW    (ISW)
  ) in_sel_i (
    .up_valid   (up_valid),
    .up_data    (up_data),
    .in_sel     (in_sel),
    .can_accept (can_accept),
    .up_ready   (up_ready),
    .sel_valid  (sel_valid),
    .sel_data   (sel_data)
  );

  hsk_xform #(
    .OP_W    (OP_W),
    .OP_MODE (OP_MODE)
  ) xform_i (
    .item (sel_data),
    .res  (xf_res)
  );

  hsk_skid_core #(
    .RES_W (RES_W)
  ) core_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (sel_valid),
    .in_res       (xf_res),
    .dn_ready_sel (dn_ready_sel),
    .can_accept   (can_accept),
    .accept       (core_accept),
    .take         (core_take),
    .out_valid    (core_valid),
    .out_data     (core_data),
    .skid_full    (core_skid_full)
  );

  hsk_out_route #(
    .NUM_OUT (NUM_OUT),
    .RES_W   (RES_W),
    .OSW     (OSW)
  ) route_i (
    .out_valid    (core_valid),
    .out_data     (core_data),
    .out_sel      (out_sel),
    .dn_ready     (dn_ready),
    .dn_valid     (dn_valid),
    .dn_data      (dn_data),
    .dn_ready_sel (dn_ready_sel)
  );

endmodule

// File: rtl/hsk_mport_stage_chk.sv
module hsk_mport_stage_chk #(
  parameter int NUM_IN  = 1,
  parameter int NUM_OUT = 1,
  parameter int RES_W   = 9
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IN-1:0]  up_ready,
  input logic [NUM_OUT-1:0] dn_valid,
  input logic               core_valid,
  input logic [RES_W-1:0]   core_data,
  input logic               core_skid_full,
  input logic               core_take,
  input logic               core_accept
);

  // R3: at most one upstream port sees ready.
  a_r3_ready_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(up_ready));

  // R4: at most one downstream port sees valid.
  a_r4_valid_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_valid));

  // R5: a full skid register blocks every upstream port.
  a_r5_skid_blocks: assert property (@(posedge clk) disable iff (rst)
    core_skid_full |-> (up_ready == '0));

  // R5: an item accepted during a stall lands in the skid register.
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    (core_valid && !core_take && core_accept) |=> core_skid_full);

  // R6: a buffered item moves to the output before anything newer.
  a_r6_skid_first: assert property (@(posedge clk) disable iff (rst)
    (core_skid_full && core_take) |=> (core_valid && !core_skid_full));

  // R7: an untaken result stays valid and unchanged.
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (core_valid && !core_take) |=> (core_valid && $stable(core_data)));

  // R8: both registers are empty right after reset.
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!core_valid && !core_skid_full));

endmodule

bind hsk_mport_stage hsk_mport_stage_chk #(
  .NUM_IN  (NUM_IN),
  .NUM_OUT (NUM_OUT),
  .RES_W   (RES_W)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .up_ready       (up_ready),
  .dn_valid       (dn_valid),
  .core_valid     (core_valid),
  .core_data      (core_data),
  .core_skid_full (core_skid_full),
  .core_take      (core_take),
  .core_accept    (core_accept)
);

// File: tb/hsk_mport_stage_tb_lane.sv
module hsk_mport_stage_tb_lane
  import hsk_pkg::*;
#(
  parameter int NUM_IN   = 1,
  parameter int NUM_OUT  = 1,
  parameter int OP_W     = 8,
  parameter int OP_MODE  = 0,
  parameter int SEED     = 1,
  parameter int RAND_CYC = 3000
) (
  input  logic clk,
  output logic done,
  output int   checks,
  output int   errors
);

  localparam int IN_W  = 2 * OP_W;
  localparam int RES_W = OP_W + 1;
  localparam int ISW   = sel_w(NUM_IN);
  localparam int OSW   = sel_w(NUM_OUT);

  logic                     rst;
  logic [NUM_IN-1:0]        up_valid;
  logic [NUM_IN*IN_W-1:0]   up_data;
  logic [NUM_IN-1:0]        up_ready;
  logic [ISW-1:0]           in_sel;
  logic [NUM_OUT-1:0]       dn_valid;
  logic [NUM_OUT*RES_W-1:0] dn_data;
  logic [NUM_OUT-1:0]       dn_ready;
  logic [OSW-1:0]           out_sel;

  logic [RES_W-1:0] exp_q[$];
  bit               hold_pend;
  int               hold_idx;
  logic [RES_W-1:0] hold_data;

  hsk_mport_stage #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .OP_W    (OP_W),
    .OP_MODE (OP_MODE)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .up_data  (up_data),
    .up_ready (up_ready),
    .in_sel   (in_sel),
    .dn_valid (dn_valid),
    .dn_data  (dn_data),
    .dn_ready (dn_ready),
    .out_sel  (out_sel)
  );

  // Reference transform (R2)
  function automatic logic [RES_W-1:0] model(input logic [IN_W-1:0] item);
    logic [RES_W-1:0] a;
    logic [RES_W-1:0] b;
    a = {1'b0, item[IN_W-1:OP_W]};
    b = {1'b0, item[OP_W-1:0]};
    case (OP_MODE)
      0:       return a + b;
      1:       return a - b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic int in_idx();
    if (NUM_IN == 1) return 0;
    if (int'(in_sel) < NUM_IN) return int'(in_sel);
    return -1;
  endfunction

  function automatic int out_idx();
    if (NUM_OUT == 1) return 0;
    if (int'(out_sel) < NUM_OUT) return int'(out_sel);
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (lane seed %0d): actual %0h expected %0h", tag, SEED, act, exp_v);
    end
  endtask

  // Per-cycle monitor and scoreboard; runs after inputs settle.
  task automatic mon();
    int ii;
    int oi;
    logic [NUM_IN-1:0]  rmask;
    logic [NUM_OUT-1:0] vmask;
    logic [RES_W-1:0]   got;
    logic [RES_W-1:0]   want;
    ii = in_idx();
    oi = out_idx();
    rmask = '0;
    vmask = '0;
    if (ii >= 0) rmask[ii] = 1'b1;
    if (oi >= 0) vmask[oi] = 1'b1;
    chk((up_ready & ~rmask) == '0, "R3 ready only on selected upstream port",
        32'(up_ready), 32'(rmask));
    chk((dn_valid & ~vmask) == '0, "R4 valid only on selected downstream port",
        32'(dn_valid), 32'(vmask));
    if (hold_pend && oi == hold_idx) begin
      chk(dn_valid[oi] && dn_data[oi*RES_W +: RES_W] == hold_data, "R7 stalled result held",
          32'(dn_data[oi*RES_W +: RES_W]), 32'(hold_data));
    end
    hold_pend = 1'b0;
    if (oi >= 0 && dn_valid[oi]) begin
      got = dn_data[oi*RES_W +: RES_W];
      if (dn_ready[oi]) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 output with nothing pending", 32'(got), 32'(0));
        end else begin
          want = exp_q.pop_front();
          chk(got == want, "R2 R6 result value and order", 32'(got), 32'(want));
        end
      end else begin
        hold_pend = 1'b1;
        hold_idx  = oi;
        hold_data = got;
      end
    end
    if (ii >= 0 && up_valid[ii] && up_ready[ii]) begin
      exp_q.push_back(model(up_data[ii*IN_W +: IN_W]));
    end
  endtask

  task automatic settle();
    #5;
    mon();
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic drain();
    up_valid = '0;
    dn_ready = '1;
    out_sel  = '0;
    in_sel   = '0;
    repeat (4) begin
      settle();
      nxt();
    end
  endtask

  initial begin
    logic [IN_W-1:0] d1;
    logic [IN_W-1:0] d2;
    logic [IN_W-1:0] d3;
    void'($urandom(SEED));
    done = 1'b0; checks = 0; errors = 0;
    hold_pend = 1'b0; hold_idx = 0; hold_data = '0;
    rst = 1'b1; up_valid = '0; up_data = '0; in_sel = '0; out_sel = '0; dn_ready = '0;
    repeat (3) nxt();
    rst = 1'b0;
    settle();
    chk(dn_valid == '0, "R8 no valid after reset", 32'(dn_valid), 32'(0));
    chk(up_ready[0] == 1'b1, "R8 selected port ready after reset", 32'(up_ready), 32'(1));
    nxt();

    // Stall, skid capture and ordering: R1 R5 R6 R7
    drain();
    d1 = {{(OP_W-4){1'b1}}, 4'h0, 4'h2, {(OP_W-4){1'b0}}};
    d2 = IN_W'(16'h0509);
    d3 = '1;
    dn_ready = '0;
    up_valid = NUM_IN'(1);
    up_data[0 +: IN_W] = d1;
    settle();
    chk(up_ready[0], "R5 ready while skid empty", 32'(up_ready), 32'(1));
    nxt();
    up_data[0 +: IN_W] = d2;
    settle();
    chk(dn_valid[0] && dn_data[0 +: RES_W] == model(d1), "R1 result one cycle after accept",
        32'(dn_data[0 +: RES_W]), 32'(model(d1)));
    chk(up_ready[0], "R5 ready before skid fills", 32'(up_ready), 32'(1));
    nxt();
    up_data[0 +: IN_W] = d3;
    settle();
    chk(up_ready == '0, "R5 ready low while skid full", 32'(up_ready), 32'(0));
    chk(dn_valid[0] && dn_data[0 +: RES_W] == model(d1), "R7 first result held",
        32'(dn_data[0 +: RES_W]), 32'(model(d1)));
    nxt();
    dn_ready = '1;
    settle();
    chk(up_ready == '0, "R5 ready low until drained", 32'(up_ready), 32'(0));
    nxt();
    settle();
    chk(dn_valid[0] && dn_data[0 +: RES_W] == model(d2), "R6 buffered item comes next",
        32'(dn_data[0 +: RES_W]), 32'(model(d2)));
    chk(up_ready[0], "R5 ready returns after drain", 32'(up_ready), 32'(1));
    nxt();
    up_valid = '0;
    settle();
    chk(dn_valid[0] && dn_data[0 +: RES_W] == model(d3), "R6 newest item last",
        32'(dn_data[0 +: RES_W]), 32'(model(d3)));
    nxt();
    drain();

    if (NUM_IN > 1) begin
      // R3: valid on an unselected port is ignored
      in_sel = '0;
      up_valid = NUM_IN'(2);
      settle();
      chk(up_ready[1] == 1'b0, "R3 unselected port not ready", 32'(up_ready), 32'(1));
      nxt();
      up_valid = '0;
      settle();
      chk(dn_valid == '0, "R3 unselected valid ignored", 32'(dn_valid), 32'(0));
      nxt();
      if (NUM_IN < (1 << ISW)) begin
        // R3: out-of-range select serves nobody
        in_sel = ISW'(NUM_IN);
        up_valid = '1;
        settle();
        chk(up_ready == '0, "R3 out-of-range select serves none", 32'(up_ready), 32'(0));
        nxt();
        up_valid = '0;
        in_sel = '0;
        settle();
        chk(dn_valid == '0, "R3 out-of-range select takes nothing", 32'(dn_valid), 32'(0));
        nxt();
      end
    end else begin
      // R9: single upstream port ignores in_sel
      in_sel = '1;
      up_valid = '1;
      up_data[0 +: IN_W] = d2;
      settle();
      chk(up_ready[0], "R9 single input ignores selector", 32'(up_ready), 32'(1));
      nxt();
      up_valid = '0;
      settle();
      chk(dn_valid[0], "R9 single input item delivered", 32'(dn_valid), 32'(1));
      nxt();
    end
    drain();

    if (NUM_OUT == 1) begin
      // R9: single downstream port ignores out_sel
      out_sel = '1;
      up_valid = NUM_IN'(1);
      up_data[0 +: IN_W] = d1;
      settle();
      nxt();
      up_valid = '0;
      settle();
      chk(dn_valid[0], "R9 single output ignores selector", 32'(dn_valid), 32'(1));
      nxt();
    end else if (NUM_OUT < (1 << OSW)) begin
      // R4: out-of-range out_sel offers nothing and keeps the item
      out_sel = OSW'(NUM_OUT);
      up_valid = NUM_IN'(1);
      up_data[0 +: IN_W] = d1;
      settle();
      nxt();
      up_valid = '0;
      settle();
      chk(dn_valid == '0, "R4 out-of-range route offers none", 32'(dn_valid), 32'(0));
      nxt();
      out_sel = OSW'(NUM_OUT - 1);
      settle();
      chk(dn_valid[NUM_OUT-1] && dn_data[(NUM_OUT-1)*RES_W +: RES_W] == model(d1),
          "R4 item kept and offered on new port",
          32'(dn_data[(NUM_OUT-1)*RES_W +: RES_W]), 32'(model(d1)));
      nxt();
    end
    drain();

    // Constrained random traffic with operand corners
    for (int c = 0; c < RAND_CYC; c++) begin
      if ($urandom_range(0, 7) == 0) in_sel = ISW'($urandom_range(0, NUM_IN));
      if ($urandom_range(0, 7) == 0) out_sel = OSW'($urandom_range(0, NUM_OUT));
      up_valid = NUM_IN'($urandom);
      for (int p = 0; p < NUM_IN; p++) begin
        case ($urandom_range(0, 9))
          0:       up_data[p*IN_W +: IN_W] = '1;
          1:       up_data[p*IN_W +: IN_W] = {{OP_W{1'b0}}, {OP_W{1'b1}}};
          default: up_data[p*IN_W +: IN_W] = IN_W'($urandom);
        endcase
      end
      dn_ready = ($urandom_range(0, 3) != 0) ? NUM_OUT'($urandom) : '1;
      settle();
      nxt();
    end

    up_valid = '0;
    dn_ready = '1;
    out_sel  = '0;
    repeat (8) begin
      settle();
      nxt();
    end
    chk(exp_q.size() == 0, "R5 R6 no accepted item lost", 32'(exp_q.size()), 32'(0));
    done = 1'b1;
  end

endmodule

// File: tb/hsk_mport_stage_tb_top.sv
module hsk_mport_stage_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic done_a, done_b, done_c;
  int   chk_a, chk_b, chk_c;
  int   err_a, err_b, err_c;

  // Several upstream ports, add transform.
  hsk_mport_stage_tb_lane #(
    .NUM_IN (3), .NUM_OUT (1), .OP_W (8), .OP_MODE (0), .SEED (11)
  ) lane_in_i (.clk (clk), .done (done_a), .checks (chk_a), .errors (err_a));

  // Several downstream ports, subtract transform.
  hsk_mport_stage_tb_lane #(
    .NUM_IN (1), .NUM_OUT (3), .OP_W (8), .OP_MODE (1), .SEED (23)
  ) lane_out_i (.clk (clk), .done (done_b), .checks (chk_b), .errors (err_b));

  // Single port each side, xor transform.
  hsk_mport_stage_tb_lane #(
    .NUM_IN (1), .NUM_OUT (1), .OP_W (8), .OP_MODE (2), .SEED (37)
  ) lane_one_i (.clk (clk), .done (done_c), .checks (chk_c), .errors (err_c));

  initial begin
    int cyc;
    int tot_chk;
    int tot_err;
    cyc = 0;
    while (!(done_a && done_b && done_c) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    #1;
    tot_chk = chk_a + chk_b + chk_c;
    tot_err = err_a + err_b + err_c;
    if (!(done_a && done_b && done_c)) begin
      tot_chk++;
      tot_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", tot_chk, tot_err);
    $finish;
  end

endmodule